// File: doc/BRIEF.md
# Configurable Pulse Train Modulator

This block drives one always-output pin with either a plain data bit or a periodic carrier. A single control register, written and read back through a simple register port, holds an on-time field and a mode field. The mode selects how long the low phase lasts. The low phase is always a whole multiple (one, two or three) of the high phase. The high phase lasts (on-time + 1) clocks. In the carrier modes the pin carries the waveform ANDed with the port data bit, so software can silence the carrier without reprogramming it.

Once per carrier period the block raises a one-clock strobe, which a neighbouring timer counts to measure carrier periods. Any write to the control register restarts the waveform at the start of its high phase. The write also resets the period position, so the strobe timing is realigned at once.

Top module: `pulse_modulator`

## Requirements
- R1: While reset is asserted and after reset, the control register reads 0x00, `mod_out` equals `port_bit` and `period_strobe` is low.
- R2: A write with `reg_wr_en` high is captured at the clock edge, and `reg_rdata` shows the written byte from the next cycle. Bits [4:0] hold the on-time N and bits [7:5] hold the mode.
- R3: With mode 000 or any mode from 100 to 111, `mod_out` follows `port_bit` in the same cycle and `period_strobe` stays low.
- R4: With mode 001, the carrier is high for N+1 clocks and then low for N+1 clocks, repeating. For example, N = 3 gives an 8-clock period.
- R5: With mode 010, the carrier is high for N+1 clocks and then low for 2·(N+1) clocks, repeating.
- R6: With mode 011, the carrier is high for N+1 clocks and then low for 3·(N+1) clocks, repeating.
- R7: In the first cycle after any register write, a carrier mode's waveform is in the first clock of its high phase.
- R8: In a carrier mode, `mod_out` is the carrier ANDed with `port_bit`. Holding `port_bit` at 0 forces `mod_out` low but does not disturb the period timing or the strobe.
- R9: In a carrier mode, `period_strobe` is high for exactly one clock per period: the last clock of each low phase.
- R10: The extreme on-times work. N = 0 in mode 001 gives a 2-clock period, and N = 31 gives 32-clock units.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read data |
| port_bit | input | 1 | Port data bit: the pass-through value, or the carrier gate |
| mod_out | output | 1 | Modulated output pin |
| period_strobe | output | 1 | One-clock pulse at the end of each carrier period |

## Verification
The assertions assume that the on-time and mode change only through a register write. They also assume that a write always restarts the counters, so the unit counter can never sit above a newly written, smaller on-time. The stimulus respects this by changing the register only through the write port. The stimulus also drives `port_bit` and the write inputs one nanosecond after a falling edge. This keeps the combinational path from `port_bit` to `mod_out` stable at each sampling point. Writes are placed both at period boundaries and in the middle of high and low phases, to exercise the restart.

// File: rtl/modulator_pkg.sv
package modulator_pkg;

   // carrier phase within one period
   typedef enum logic {
      PH_HIGH = 1'b0,
      PH_LOW  = 1'b1
   } phase_e;

   // largest low-phase multiple of the high time
   localparam int MAX_LOW_UNITS = 3;
   localparam int LOW_UNITS_W   = $clog2(MAX_LOW_UNITS + 1);

   // mode codes that enable a carrier
   localparam int MODE_HALF    = 1;
   localparam int MODE_THIRD   = 2;
   localparam int MODE_QUARTER = 3;

endpackage

// File: rtl/mod_ctrl_reg.sv
module mod_ctrl_reg #(
   parameter int ON_W   = 5,
   parameter int MODE_W = 3,
   localparam int REG_W = ON_W + MODE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [REG_W-1:0]  wdata,
   output logic [REG_W-1:0]  rdata,
   output logic [ON_W-1:0]   on_time,
   output logic [MODE_W-1:0] mode
);

   logic [REG_W-1:0] ctrl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (wr_en) begin
         ctrl_q <= wdata;
      end
   end

   assign rdata   = ctrl_q;
   assign on_time = ctrl_q[ON_W-1:0];
   assign mode    = ctrl_q[REG_W-1:ON_W];

   AST_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (rdata == $past(wdata))); // R2

endmodule

// File: rtl/mod_mode_decode.sv
module mod_mode_decode
   import modulator_pkg::*;
#(
   parameter int MODE_W = 3
) (
   input  logic [MODE_W-1:0]      mode,
   output logic                   active,
   output logic [LOW_UNITS_W-1:0] low_units
);

   always_comb begin
      active    = 1'b1;
      low_units = LOW_UNITS_W'(1);
      if (mode == MODE_W'(MODE_HALF)) begin
         low_units = LOW_UNITS_W'(1);
      end else if (mode == MODE_W'(MODE_THIRD)) begin
         low_units = LOW_UNITS_W'(2);
      end else if (mode == MODE_W'(MODE_QUARTER)) begin
         low_units = LOW_UNITS_W'(3);
      end else begin
         active    = 1'b0;
      end
   end

endmodule

// File: rtl/mod_phase_seq.sv
module mod_phase_seq
   import modulator_pkg::*;
#(
   parameter int ON_W = 5
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   restart,
   input  logic                   active,
   input  logic [ON_W-1:0]        on_time,
   input  logic [LOW_UNITS_W-1:0] low_units,
   output logic                   wave_high,
   output logic                   period_end
);

   phase_e                 phase_q;
   logic [ON_W-1:0]        seg_q;
   logic [LOW_UNITS_W-1:0] unit_q;
   logic                   seg_last;
   logic                   unit_last;

   assign seg_last   = (seg_q == on_time);
   assign unit_last  = (unit_q == (low_units - LOW_UNITS_W'(1)));
   assign wave_high  = (phase_q == PH_HIGH);
   assign period_end = active && (phase_q == PH_LOW) && seg_last && unit_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_HIGH;
         seg_q   <= '0;
         unit_q  <= '0;
      end else if (restart || !active) begin
         phase_q <= PH_HIGH;
         seg_q   <= '0;
         unit_q  <= '0;
      end else if (!seg_last) begin
         seg_q   <= seg_q + ON_W'(1);
      end else begin
         seg_q <= '0;
         if (phase_q == PH_HIGH) begin
            phase_q <= PH_LOW;
            unit_q  <= '0;
         end else if (unit_last) begin
            phase_q <= PH_HIGH;
            unit_q  <= '0;
         end else begin
            unit_q  <= unit_q + LOW_UNITS_W'(1);
         end
      end
   end

   AST_RESTART_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (wave_high && seg_q == '0)); // R7

   AST_SEG_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !restart) |-> (seg_q <= on_time)); // R4

   AST_HIGH_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !restart && wave_high && seg_last) |=> !wave_high); // R4

   AST_STROBE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (period_end && !restart) |=> (wave_high && seg_q == '0)); // R9

endmodule

// File: rtl/pulse_modulator.sv
module pulse_modulator
   import modulator_pkg::*;
#(
   parameter int ON_W         = 5,
   parameter int MODE_W       = 3,
   parameter bit GATE_CARRIER = 1'b1,
   localparam int REG_W       = ON_W + MODE_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr_en,
   input  logic [REG_W-1:0] reg_wdata,
   output logic [REG_W-1:0] reg_rdata,
   input  logic             port_bit,
   output logic             mod_out,
   output logic             period_strobe
);

   generate
      if (ON_W < 1) begin : g_bad_on_w
         $error("pulse_modulator: ON_W must be at least 1");
      end
      if (MODE_W < 2) begin : g_bad_mode_w
         $error("pulse_modulator: MODE_W must be at least 2");
      end
   endgenerate

   logic [ON_W-1:0]        on_time;
   logic [MODE_W-1:0]      mode;
   logic                   active;
   logic [LOW_UNITS_W-1:0] low_units;
   logic                   wave_high;
   logic                   period_end;

   mod_ctrl_reg #(.ON_W(ON_W), .MODE_W(MODE_W)) u_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (reg_wr_en),
      .wdata   (reg_wdata),
      .rdata   (reg_rdata),
      .on_time (on_time),
      .mode    (mode)
   );

   mod_mode_decode #(.MODE_W(MODE_W)) u_dec (
      .mode      (mode),
      .active    (active),
      .low_units (low_units)
   );

   mod_phase_seq #(.ON_W(ON_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .restart    (reg_wr_en),
      .active     (active),
      .on_time    (on_time),
      .low_units  (low_units),
      .wave_high  (wave_high),
      .period_end (period_end)
   );

   generate
      if (GATE_CARRIER) begin : g_gated
         assign mod_out = active ? (wave_high & port_bit) : port_bit;
      end else begin : g_raw
         assign mod_out = active ? wave_high : port_bit;
      end
   endgenerate

   assign period_strobe = period_end;

   AST_OFF_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      !active |-> !period_strobe); // R3

   AST_STROBE_IN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      period_strobe |-> !wave_high); // R9

endmodule

// File: tb/test_pulse_modulator.sv
`timescale 1ns/1ps
module test_pulse_modulator;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr_en = 1'b0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic       port_bit = 1'b0;
   logic       mod_out;
   logic       period_strobe;

   int    errors = 0;
   int    checks = 0;
   bit    finished = 1'b0;
   string cur_req = "R1";

   always #2.5 clk = ~clk;

   pulse_modulator i_pulse_modulator (
      .clk           (clk),
      .rst_n         (rst_n),
      .reg_wr_en     (reg_wr_en),
      .reg_wdata     (reg_wdata),
      .reg_rdata     (reg_rdata),
      .port_bit      (port_bit),
      .mod_out       (mod_out),
      .period_strobe (period_strobe)
   );

   // ---------------- reference model ----------------
   logic [7:0] m_reg;
   int         m_pos;

   function automatic int m_mode();
      return int'(m_reg[7:5]);
   endfunction
   function automatic bit m_act();
      return (m_mode() >= 1) && (m_mode() <= 3);
   endfunction
   function automatic int m_unit();
      return int'(m_reg[4:0]) + 1;
   endfunction
   function automatic int m_period();
      return m_unit() * (1 + m_mode());
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_reg = 8'h00;
         m_pos = 0;
      end else if (reg_wr_en) begin
         m_reg = reg_wdata;
         m_pos = 0;
      end else if (m_act()) begin
         m_pos = (m_pos + 1) % m_period();
      end
   end

   always @(negedge clk) begin
      if (!finished) begin
         bit exp_out, exp_str;
         if (m_act()) begin
            exp_out = (m_pos < m_unit()) && port_bit;
            exp_str = (m_pos == m_period() - 1);
         end else begin
            exp_out = port_bit;
            exp_str = 1'b0;
         end
         checks += 3;
         if (mod_out !== exp_out) begin
            errors++;
            $display("FAIL %s mod_out actual=%b expected=%b at %0t", cur_req, mod_out, exp_out, $time);
         end
         if (period_strobe !== exp_str) begin
            errors++;
            $display("FAIL %s period_strobe actual=%b expected=%b at %0t", cur_req, period_strobe, exp_str, $time);
         end
         if (reg_rdata !== m_reg) begin
            errors++;
            $display("FAIL %s reg_rdata actual=%h expected=%h at %0t", cur_req, reg_rdata, m_reg, $time);
         end
      end
   end

   // ---------------- stimulus ----------------
   task automatic step(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         #1;
      end
   endtask

   task automatic write_reg(logic [7:0] v);
      @(negedge clk);
      #1;
      reg_wr_en = 1'b1;
      reg_wdata = v;
      @(negedge clk);
      #1;
      reg_wr_en = 1'b0;
   endtask

   function automatic logic [7:0] mk(int mode, int on);
      return {3'(mode), 5'(on)};
   endfunction

   initial begin
      // R1: reset state with port toggling
      cur_req = "R1";
      for (int i = 0; i < 4; i++) begin
         step(1);
         port_bit = ~port_bit;
      end
      rst_n = 1'b1;
      for (int i = 0; i < 4; i++) begin
         step(1);
         port_bit = ~port_bit;
      end

      // R2: register readback, several patterns
      cur_req = "R2";
      write_reg(8'hA5);
      step(2);
      write_reg(8'h1F);
      step(2);

      // R3: off modes pass the port bit through
      cur_req = "R3";
      for (int md = 4; md < 8; md++) begin
         write_reg(mk(md, 5));
         for (int i = 0; i < 6; i++) begin
            step(1);
            port_bit = (i % 3) != 0;
         end
      end
      write_reg(mk(0, 9));
      for (int i = 0; i < 6; i++) begin
         step(1);
         port_bit = ~port_bit;
      end

      // R4: half duty, N=3 gives 8-clock period
      port_bit = 1'b1;
      cur_req = "R4";
      write_reg(mk(1, 3));
      step(40);

      // R5: third duty
      cur_req = "R5";
      write_reg(mk(2, 2));
      step(45);

      // R6: quarter duty
      cur_req = "R6";
      write_reg(mk(3, 1));
      step(40);

      // R9: strobe placement over a longer quarter-duty run
      cur_req = "R9";
      write_reg(mk(3, 4));
      step(80);

      // R10: extreme on-times
      cur_req = "R10";
      write_reg(mk(1, 0));
      step(12);
      write_reg(mk(1, 31));
      step(140);
      write_reg(mk(3, 0));
      step(12);

      // R7: writes landing mid-high and mid-low restart the waveform
      cur_req = "R7";
      write_reg(mk(2, 3));
      step(2);
      write_reg(mk(2, 3));
      step(6);
      write_reg(mk(1, 5));
      step(9);
      write_reg(mk(3, 2));
      step(20);

      // R8: port bit gates the carrier, timing unchanged
      cur_req = "R8";
      write_reg(mk(1, 2));
      port_bit = 1'b0;
      step(20);
      begin
         logic [7:0] lf = 8'h5B;
         for (int i = 0; i < 60; i++) begin
            step(1);
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
            port_bit = lf[0];
         end
      end
      port_bit = 1'b1;
      step(4);

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      for (int i = 0; i < 20000; i++) begin
         @(posedge clk);
      end
      if (!finished) begin
         finished = 1'b1;
         errors++;
         checks++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule